// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This block collects interrupt requests from a small set of sources and decides which one is serviced next. A rising edge on a request input sets a dedicated cell that stays set until the cell is cleared on purpose. A priority encoder continuously picks the lowest-numbered set cell. A pending flag tells the sequencer that an interrupt could be taken now.

The sequencer then works through three separate active-low pulses. The capture pulse copies the winning code into a holding register. The read strobe places the matching vector address on a 16-bit read bus. The knock-down pulse clears the cell named by the held code, and the next request in line surfaces.

Two independent inhibit flags, each with its own set and clear pulse, mask the pending flag and block capture while either one is set. Saving and restoring the interrupted program's state is handled elsewhere.

Top module: `irq_prio_unit`

## Requirements
- R1: A low-to-high transition on `req_i[n]`, seen on consecutive clock edges, sets cell n at that edge. A cell stays set while its request is held high or dropped, and only a knock-down clears it. A request held high does not set its cell again after the cell is cleared.
- R2: Among the set cells, the lowest index has the highest priority. Cell 0 wins over every other cell.
- R3: A clock edge with `capture_n` low, `knock_n` high and `pending_o` high loads the winning code into the holding register and marks the held code valid. Otherwise `capture_n` leaves the held code and its valid mark unchanged.
- R4: While `vec_rd_n` is low and a valid code is held, `rd_bus_o` equals VEC_BASE + 4 × code (VEC_BASE defaults to 0x0400). In every other case `rd_bus_o` is 0. The bus is combinational in `vec_rd_n`.
- R5: A clock edge with `knock_n` low and a valid held code clears the cell named by that code and invalidates the held code. The next pending request then drives `pending_o`. A knock-down with no valid code changes nothing.
- R6: A request edge on another cell at the same edge as a knock-down is kept. A new edge on the cell being cleared wins, and that cell stays set.
- R7: When `capture_n` and `knock_n` are both low at the same edge, only the knock-down acts.
- R8: Inhibit flag A is set by `inh_a_set_n` low and cleared by `inh_a_clr_n` low. Flag B works the same way with its own pair of pulses. When a flag's set and clear pulses arrive together, set wins.
- R9: `pending_o` is high exactly when at least one cell is set and neither inhibit flag is set.
- R10: Reset (`rst_n` low) empties all cells, invalidates the held code and clears both inhibit flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC (5) | Interrupt request levels; a rising edge sets a cell |
| capture_n | input | 1 | Active-low pulse that captures the winning code |
| vec_rd_n | input | 1 | Active-low read strobe for the vector address |
| knock_n | input | 1 | Active-low pulse that clears the serviced cell |
| inh_a_set_n | input | 1 | Active-low set of inhibit flag A |
| inh_a_clr_n | input | 1 | Active-low clear of inhibit flag A |
| inh_b_set_n | input | 1 | Active-low set of inhibit flag B |
| inh_b_clr_n | input | 1 | Active-low clear of inhibit flag B |
| rd_bus_o | output | BUS_W (16) | Vector address during the read strobe, otherwise 0 |
| pending_o | output | 1 | An interrupt can be taken now |

## Verification
A faulty cell shows up on `pending_o` at the very next clock edge. This covers a missed edge, a cell lost during a knock-down, or a cell set again by a held level. A wrong winner or a stale held code shows up on `rd_bus_o` as soon as the read strobe follows a capture. The scenarios therefore pair every capture with a read, and every knock-down with a check of the pending flag. Some cases arrive together at one edge: knock-down with capture, set with clear, and clear with a fresh edge. Each of these is followed by a read or a pending check, so a wrong precedence becomes visible within one cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   typedef struct packed {
      logic main_blk;
      logic aux_blk;
   } inh_state_t;

   // set pulse dominates clear pulse
   function automatic logic set_clr_next(input logic cur, input logic set_p, input logic clr_p);
      if (set_p)
         return 1'b1;
      else if (clr_p)
         return 1'b0;
      else
         return cur;
   endfunction

endpackage

// File: rtl/irq_req_cells.sv
module irq_req_cells #(
   parameter int NUM_SRC  = 5,
   parameter int SYNC_REQ = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] clr_mask_i,
   output logic [NUM_SRC-1:0] cells_o
);

   logic [NUM_SRC-1:0] req_s;
   logic [NUM_SRC-1:0] req_q;
   logic [NUM_SRC-1:0] rise;

   generate
      if (SYNC_REQ != 0) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)
               req_s <= '0;
            else
               req_s <= req_i;
         end
      end else begin : g_direct
         assign req_s = req_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         req_q <= '0;
      else
         req_q <= req_s;
   end

   assign rise = req_s & ~req_q;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
         always_ff @(posedge clk) begin
            if (!rst_n)
               cells_o[i] <= 1'b0;
            else if (rise[i])
               cells_o[i] <= 1'b1;
            else if (clr_mask_i[i])
               cells_o[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 5,
   parameter int CODE_W  = 3
) (
   input  logic [NUM_SRC-1:0] cells_i,
   output logic [CODE_W-1:0]  code_o,
   output logic               any_o
);

   always_comb begin
      code_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cells_i[i])
            code_o = CODE_W'(i);
      end
   end

   assign any_o = |cells_i;

endmodule

// File: rtl/irq_vec_hold.sv
module irq_vec_hold #(
   parameter int NUM_SRC  = 5,
   parameter int CODE_W   = 3,
   parameter int BUS_W    = 16,
   parameter int VEC_BASE = 'h0400
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic               knock_i,
   input  logic               rd_en_i,
   input  logic [CODE_W-1:0]  code_i,
   output logic [CODE_W-1:0]  code_q,
   output logic               valid_q,
   output logic [NUM_SRC-1:0] clr_mask_o,
   output logic [BUS_W-1:0]   bus_o
);

   localparam logic [BUS_W-1:0] BASE_V = BUS_W'(VEC_BASE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         valid_q <= 1'b0;
      end else if (knock_i) begin
         valid_q <= 1'b0;
      end else if (take_i) begin
         code_q  <= code_i;
         valid_q <= 1'b1;
      end
   end

   assign clr_mask_o = (knock_i && valid_q) ? (NUM_SRC'(1) << code_q) : '0;
   assign bus_o      = (rd_en_i && valid_q) ? (BASE_V + (BUS_W'(code_q) << 2)) : '0;

endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
   import irq_prio_pkg::*;
#(
   parameter int NUM_SRC  = 5,
   parameter int BUS_W    = 16,
   parameter int VEC_BASE = 'h0400,
   parameter int SYNC_REQ = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               capture_n,
   input  logic               vec_rd_n,
   input  logic               knock_n,
   input  logic               inh_a_set_n,
   input  logic               inh_a_clr_n,
   input  logic               inh_b_set_n,
   input  logic               inh_b_clr_n,
   output logic [BUS_W-1:0]   rd_bus_o,
   output logic               pending_o
);

   localparam int CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   generate
      if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
         $error("irq_prio_unit: NUM_SRC must lie in 2..32");
      end
      if (BUS_W < 4 || BUS_W > 32) begin : g_bad_bus
         $error("irq_prio_unit: BUS_W must lie in 4..32");
      end
      if ((longint'(VEC_BASE) + longint'(4 * (NUM_SRC - 1))) >= (longint'(1) << BUS_W)) begin : g_bad_base
         $error("irq_prio_unit: vector table does not fit on the read bus");
      end
   endgenerate

   logic [NUM_SRC-1:0] req_cells;
   logic [NUM_SRC-1:0] clr_mask;
   logic [CODE_W-1:0]  win_code;
   logic               any_set;
   logic [CODE_W-1:0]  held_code;
   logic               held_vld;
   logic               take;
   inh_state_t         inh_q;

   irq_req_cells #(
      .NUM_SRC (NUM_SRC),
      .SYNC_REQ(SYNC_REQ)
   ) cells_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .clr_mask_i(clr_mask),
      .cells_o   (req_cells)
   );

   irq_prio_enc #(
      .NUM_SRC(NUM_SRC),
      .CODE_W (CODE_W)
   ) enc_i (
      .cells_i(req_cells),
      .code_o (win_code),
      .any_o  (any_set)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inh_q <= '0;
      end else begin
         inh_q.main_blk <= set_clr_next(inh_q.main_blk, !inh_a_set_n, !inh_a_clr_n);
         inh_q.aux_blk  <= set_clr_next(inh_q.aux_blk, !inh_b_set_n, !inh_b_clr_n);
      end
   end

   assign pending_o = any_set && !inh_q.main_blk && !inh_q.aux_blk;
   assign take      = !capture_n && pending_o;

   irq_vec_hold #(
      .NUM_SRC (NUM_SRC),
      .CODE_W  (CODE_W),
      .BUS_W   (BUS_W),
      .VEC_BASE(VEC_BASE)
   ) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (take),
      .knock_i   (!knock_n),
      .rd_en_i   (!vec_rd_n),
      .code_i    (win_code),
      .code_q    (held_code),
      .valid_q   (held_vld),
      .clr_mask_o(clr_mask),
      .bus_o     (rd_bus_o)
   );

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
   parameter int NUM_SRC = 5,
   parameter int BUS_W   = 16,
   parameter int CODE_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               capture_n,
   input logic               vec_rd_n,
   input logic               knock_n,
   input logic               inh_a_set_n,
   input logic [NUM_SRC-1:0] cells,
   input logic [CODE_W-1:0]  held_code,
   input logic               held_vld,
   input logic               inh_a,
   input logic [BUS_W-1:0]   rd_bus_o,
   input logic               pending_o
);

   // R1
   cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(knock_n) |-> ((cells & $past(cells)) == $past(cells)));

   // R3
   capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture_n && knock_n && pending_o) |=> held_vld);

   // R3
   capture_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!capture_n && knock_n && !pending_o) |=> ($stable(held_code) && $stable(held_vld)));

   // R4
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_bus_o != '0) |-> (!vec_rd_n && held_vld));

   // R5
   knock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!knock_n && held_vld) |=> !held_vld);

   // R8
   inh_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inh_a_set_n |=> inh_a);

endmodule

bind irq_prio_unit irq_prio_chk #(
   .NUM_SRC(NUM_SRC),
   .BUS_W  (BUS_W),
   .CODE_W (CODE_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .capture_n  (capture_n),
   .vec_rd_n   (vec_rd_n),
   .knock_n    (knock_n),
   .inh_a_set_n(inh_a_set_n),
   .cells      (req_cells),
   .held_code  (held_code),
   .held_vld   (held_vld),
   .inh_a      (inh_q.main_blk),
   .rd_bus_o   (rd_bus_o),
   .pending_o  (pending_o)
);

// File: tb/irq_prio_unit_tb_top.sv
module irq_prio_unit_tb_top;

   localparam int          N    = 5;
   localparam logic [15:0] BASE = 16'h0400;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         capture_n = 1'b1, vec_rd_n = 1'b1, knock_n = 1'b1;
   logic         inh_a_set_n = 1'b1, inh_a_clr_n = 1'b1, inh_b_set_n = 1'b1, inh_b_clr_n = 1'b1;
   logic [15:0]  rd_bus;
   logic         pending;

   always #10 clk = ~clk;

   irq_prio_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .capture_n  (capture_n),
      .vec_rd_n   (vec_rd_n),
      .knock_n    (knock_n),
      .inh_a_set_n(inh_a_set_n),
      .inh_a_clr_n(inh_a_clr_n),
      .inh_b_set_n(inh_b_set_n),
      .inh_b_clr_n(inh_b_clr_n),
      .rd_bus_o   (rd_bus),
      .pending_o  (pending)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // scoreboard queues
   logic [15:0] q_bus[$];
   logic        q_pend[$];
   string       q_tag[$];
   event        sample_ev;

   // reference state from the requirements
   logic [N-1:0] m_cells = '0, m_prev = '0;
   int           m_code = 0;
   bit           m_valid = 0, m_inh_a = 0, m_inh_b = 0;

   function automatic int winner(input logic [N-1:0] c);
      for (int i = 0; i < N; i++) if (c[i]) return i;
      return 0;
   endfunction

   function automatic bit m_pending();
      return (|m_cells) && !m_inh_a && !m_inh_b;
   endfunction

   // monitor: pops one expectation per sample event
   initial begin
      forever begin
         @(sample_ev);
         while (q_bus.size() > 0) begin
            logic [15:0] eb;
            logic        ep;
            string       et;
            eb = q_bus.pop_front();
            ep = q_pend.pop_front();
            et = q_tag.pop_front();
            checks++;
            if (rd_bus !== eb || pending !== ep) begin
               failures++;
               $display("FAIL %s: bus=%h pend=%b expected bus=%h pend=%b", et, rd_bus, pending, eb, ep);
            end
         end
      end
   end

   // one clock cycle of stimulus, expectation checked after the edge
   task automatic cycle(input logic [N-1:0] r, input bit cap, input bit knk,
                        input bit sa, input bit ca, input bit sb, input bit cb, input string tag);
      logic [N-1:0] clr, rise;
      bit pend_now;
      req = r;
      capture_n = !cap; knock_n = !knk;
      inh_a_set_n = !sa; inh_a_clr_n = !ca; inh_b_set_n = !sb; inh_b_clr_n = !cb;
      pend_now = m_pending();
      clr  = (knk && m_valid) ? N'(1 << m_code) : '0;
      rise = r & ~m_prev;
      m_prev = r;
      if (knk) m_valid = 0;
      else if (cap && pend_now) begin m_code = winner(m_cells); m_valid = 1; end
      m_cells = (m_cells & ~clr) | rise;
      m_inh_a = sa ? 1'b1 : (ca ? 1'b0 : m_inh_a);
      m_inh_b = sb ? 1'b1 : (cb ? 1'b0 : m_inh_b);
      @(posedge clk);
      #2;
      capture_n = 1; knock_n = 1;
      inh_a_set_n = 1; inh_a_clr_n = 1; inh_b_set_n = 1; inh_b_clr_n = 1;
      q_bus.push_back(16'h0);
      q_pend.push_back(m_pending());
      q_tag.push_back(tag);
      ->sample_ev;
      #1;
   endtask

   task automatic read_vec(input string tag);
      vec_rd_n = 0;
      #2;
      q_bus.push_back(m_valid ? BASE + 16'(4 * m_code) : 16'h0);
      q_pend.push_back(m_pending());
      q_tag.push_back(tag);
      ->sample_ev;
      #1;
      vec_rd_n = 1;
      #1;
   endtask

   task automatic idle(input logic [N-1:0] r, input string tag);
      cycle(r, 0, 0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R10 reset state
      idle('0, "R10 reset pending low");
      read_vec("R10 R4 no code held after reset");

      // R1 edge sets cell, level does not re-arm
      idle(5'b00100, "R1 rising edge sets cell 2");
      idle(5'b00100, "R1 held level keeps cell");
      cycle(5'b00100, 1, 0, 0, 0, 0, 0, "R3 capture cell 2");
      read_vec("R4 vector for code 2");
      cycle(5'b00100, 0, 1, 0, 0, 0, 0, "R5 R1 knock clears, held level no re-set");
      read_vec("R4 no vector after knock");
      idle('0, "R1 request dropped");

      // R2 priority
      idle(5'b10010, "R2 two requests pending");
      cycle(5'b10010, 1, 0, 0, 0, 0, 0, "R2 capture");
      read_vec("R2 lowest index wins (code 1)");
      cycle(5'b10010, 0, 1, 0, 0, 0, 0, "R5 next request surfaces");
      cycle(5'b10010, 1, 0, 0, 0, 0, 0, "R5 capture next");
      read_vec("R5 vector for code 4");
      cycle(5'b10010, 0, 1, 0, 0, 0, 0, "R5 all cleared");
      idle('0, "R1 drop");

      // R8 / R9 inhibits
      cycle('0, 0, 0, 1, 0, 0, 0, "R8 set inhibit A");
      idle(5'b01000, "R9 masked by inhibit A");
      cycle(5'b01000, 1, 0, 0, 0, 0, 0, "R3 capture blocked by inhibit");
      read_vec("R3 no code captured while inhibited");
      cycle(5'b01000, 0, 0, 0, 1, 1, 0, "R9 inhibit B masks");
      cycle(5'b01000, 0, 0, 0, 0, 0, 1, "R9 pending back");
      cycle(5'b01000, 0, 0, 1, 1, 0, 0, "R8 set wins over clear");
      cycle(5'b01000, 0, 0, 0, 1, 0, 0, "R8 clear inhibit A");

      // R6 edges during knock
      cycle(5'b01000, 1, 0, 0, 0, 0, 0, "R6 capture code 3");
      idle('0, "R6 request 3 dropped, cell held");
      cycle(5'b01001, 0, 1, 0, 0, 0, 0, "R6 knock with new edges on 0 and 3");
      cycle(5'b01001, 1, 0, 0, 0, 0, 0, "R6 capture after knock");
      read_vec("R6 edge on other cell kept (code 0)");
      cycle(5'b01001, 0, 1, 0, 0, 0, 0, "R6 knock code 0");
      cycle(5'b01001, 1, 0, 0, 0, 0, 0, "R6 capture re-set cell");
      read_vec("R6 edge on cleared cell wins (code 3)");
      cycle(5'b01001, 0, 1, 0, 0, 0, 0, "R6 all cleared");
      idle('0, "R1 drop");

      // R5 / R7 precedence
      idle(5'b00001, "R1 set cell 0");
      cycle(5'b00001, 0, 1, 0, 0, 0, 0, "R5 knock without code no effect");
      cycle(5'b00001, 1, 1, 0, 0, 0, 0, "R7 knock blocks capture");
      read_vec("R7 nothing captured");
      cycle(5'b00001, 1, 0, 0, 0, 0, 0, "R3 capture code 0");
      read_vec("R4 vector for code 0");
      cycle(5'b00001, 1, 1, 0, 0, 0, 0, "R7 knock acts, capture ignored");
      read_vec("R7 no code after joint pulse");
      idle('0, "R9 idle end");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule